// File: doc/BRIEF.md
# Pointer-Masking Address Generation Unit

This unit forms the effective address of every load and store in a 64-bit core that supports pointer masking. A request supplies a source register value and either a sign-extended immediate or a second register used as an index. The sum goes through a fixed chain of three steps. First it is zero-extended when the hart runs at the narrow register width. Then, if masking is on, the bits selected by an effective mask are cleared. Last, if the base is on, an effective base is ORed in. The result is registered and comes out one cycle later with a valid strobe.

The unit also keeps its own effective mask and base. A configuration write loads raw mask and base values and the two enables. The unit then derives the effective copies from the raw values and the current width: the upper bits are cut off at narrow width, and the values are kept whole at full width. Whenever the current width changes, the control side signals it, and the effective copies are rebuilt from the stored raw values. This covers a privilege change, and it also covers a debug write to a width field. A rebuild takes one cycle. During that cycle a busy flag is raised, and any request in that same cycle still uses the old effective values.

Top module: `pm_agu`

## Requirements
- R1: With `amode_i` = 0 the raw address is `rs1_i` plus `imm_i` sign-extended from bit IMM_W-1, wrapping modulo 2^DW.
- R2: With `amode_i` = 1 the raw address is `rs1_i` plus `idx_i`, wrapping modulo 2^DW.
- R3: When `xl_narrow_i` is 1 in the request cycle, bits DW-1..NARROW_W of the sum are cleared before the mask step. This happens whether or not masking is enabled.
- R4: When the captured mask enable is 1, every address bit that is set in the effective mask is cleared.
- R5: When the captured base enable is 1, the effective base is ORed in after the mask step, so a base bit that is also covered by the mask still appears in the output.
- R6: A cycle with `csr_wr_i` = 1 captures `raw_mask_i`, `raw_base_i`, `mask_en_i` and `base_en_i`. The effective mask and base become the raw values with bits DW-1..NARROW_W forced to 0 if `xl_narrow_i` is 1, and the raw values unchanged if it is 0.
- R7: A cycle with `xl_change_i` = 1 rebuilds the effective mask and base from the stored raw values under the `xl_narrow_i` of that cycle. Without `csr_wr_i` or `xl_change_i`, the effective values never change, even if `xl_narrow_i` moves.
- R8: Effective values from a write or a rebuild apply to requests from the next cycle on. A request in the trigger cycle uses the old values. `busy_o` is 1 exactly in cycles where `csr_wr_i` or `xl_change_i` is 1.
- R9: `addr_valid_o` is 1 in the cycle after a cycle with `req_valid_i` = 1 and 0 otherwise, and `addr_o` holds its value when no request is made.
- R10: After reset `addr_valid_o` is 0, both enables are 0 (so the output is the extended sum), and the effective mask and base are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Address request |
| amode_i | input | 1 | 0: register plus immediate, 1: register plus index |
| rs1_i | input | DW | Base register value |
| imm_i | input | IMM_W | Signed immediate offset |
| idx_i | input | DW | Index register value |
| xl_narrow_i | input | 1 | Current register width is narrow (NARROW_W) |
| xl_change_i | input | 1 | Current width changed; rebuild effective mask and base |
| csr_wr_i | input | 1 | Load raw mask, base and enables |
| raw_mask_i | input | DW | Raw mask value |
| raw_base_i | input | DW | Raw base value |
| mask_en_i | input | 1 | Mask enable to capture |
| base_en_i | input | 1 | Base enable to capture |
| busy_o | output | 1 | Effective values are being rebuilt this cycle |
| addr_valid_o | output | 1 | Address output valid |
| addr_o | output | DW | Effective address |

## Verification
The bench builds the unit with DW = 16, NARROW_W = 8 and IMM_W = 4. At this size every immediate value, both address modes, both widths and all four enable combinations can be swept against a spread of register values. Carries out of the narrow field and wrap-around of the full sum are hit regularly in that sweep. The small width also makes it cheap to choose mask and base patterns that overlap each other and straddle the narrow boundary. Directed sequences then cover the one-cycle window after a write or a width change, where a request must still see the old effective values.

// File: rtl/pm_agu_pkg.sv
package pm_agu_pkg;
  typedef enum logic {
    AMODE_IMM = 1'b0,
    AMODE_IDX = 1'b1
  } amode_e;
endpackage

// File: rtl/pm_agu_sum.sv
module pm_agu_sum
  import pm_agu_pkg::*;
#(
  parameter int DW    = 64,
  parameter int IMM_W = 12
) (
  input  logic             amode_i,
  input  logic [DW-1:0]    rs1_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [DW-1:0]    idx_i,
  output logic [DW-1:0]    sum_o
);
  localparam int EXT_W = DW - IMM_W;

  logic [DW-1:0] imm_sx;
  logic [DW-1:0] offs;

  assign imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    unique case (amode_e'(amode_i))
      AMODE_IDX: offs = idx_i;
      default:   offs = imm_sx;
    endcase
  end

  assign sum_o = rs1_i + offs;
endmodule

// File: rtl/pm_agu_shape.sv
module pm_agu_shape #(
  parameter int DW       = 64,
  parameter int NARROW_W = 32
) (
  input  logic [DW-1:0] sum_i,
  input  logic          narrow_i,
  input  logic          mask_en_i,
  input  logic [DW-1:0] mask_i,
  input  logic          base_en_i,
  input  logic [DW-1:0] base_i,
  output logic [DW-1:0] addr_o
);
  logic [DW-1:0] ext;
  logic [DW-1:0] masked;

  // fixed order: extend, clear, OR
  generate
    if (NARROW_W < DW) begin : g_ext
      localparam int HI_W = DW - NARROW_W;
      assign ext = narrow_i ? {{HI_W{1'b0}}, sum_i[NARROW_W-1:0]} : sum_i;
    end else begin : g_noext
      assign ext = sum_i;
    end
  endgenerate

  assign masked = mask_en_i ? (ext & ~mask_i) : ext;
  assign addr_o = base_en_i ? (masked | base_i) : masked;
endmodule

// File: rtl/pm_agu_eff.sv
module pm_agu_eff #(
  parameter int DW       = 64,
  parameter int NARROW_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          csr_wr_i,
  input  logic          xl_change_i,
  input  logic          narrow_i,
  input  logic [DW-1:0] raw_mask_i,
  input  logic [DW-1:0] raw_base_i,
  input  logic          mask_en_i,
  input  logic          base_en_i,
  output logic [DW-1:0] eff_mask_o,
  output logic [DW-1:0] eff_base_o,
  output logic          mask_en_o,
  output logic          base_en_o
);
  localparam logic [DW-1:0] KEEP_NARROW = DW'((DW+1)'(1) << NARROW_W) - DW'(1);

  logic [DW-1:0] raw_mask_q, raw_base_q;
  logic [DW-1:0] src_mask, src_base;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic nar);
    return nar ? (v & KEEP_NARROW) : v;
  endfunction

  assign src_mask = csr_wr_i ? raw_mask_i : raw_mask_q;
  assign src_base = csr_wr_i ? raw_base_i : raw_base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_mask_q <= '0;
      raw_base_q <= '0;
      mask_en_o  <= 1'b0;
      base_en_o  <= 1'b0;
    end else if (csr_wr_i) begin
      raw_mask_q <= raw_mask_i;
      raw_base_q <= raw_base_i;
      mask_en_o  <= mask_en_i;
      base_en_o  <= base_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_mask_o <= '0;
      eff_base_o <= '0;
    end else if (csr_wr_i || xl_change_i) begin
      eff_mask_o <= fit(src_mask, narrow_i);
      eff_base_o <= fit(src_base, narrow_i);
    end
  end
endmodule

// File: rtl/pm_agu.sv
module pm_agu #(
  parameter int DW       = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             amode_i,
  input  logic [DW-1:0]    rs1_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [DW-1:0]    idx_i,
  input  logic             xl_narrow_i,
  input  logic             xl_change_i,
  input  logic             csr_wr_i,
  input  logic [DW-1:0]    raw_mask_i,
  input  logic [DW-1:0]    raw_base_i,
  input  logic             mask_en_i,
  input  logic             base_en_i,
  output logic             busy_o,
  output logic             addr_valid_o,
  output logic [DW-1:0]    addr_o
);
  logic [DW-1:0] sum;
  logic [DW-1:0] shaped;
  logic [DW-1:0] eff_mask, eff_base;
  logic          mask_en_q, base_en_q;
  logic [DW-1:0] addr_q;
  logic          valid_q;

  pm_agu_sum #(.DW(DW), .IMM_W(IMM_W)) i_sum (
    .amode_i (amode_i),
    .rs1_i   (rs1_i),
    .imm_i   (imm_i),
    .idx_i   (idx_i),
    .sum_o   (sum)
  );

  pm_agu_shape #(.DW(DW), .NARROW_W(NARROW_W)) i_shape (
    .sum_i     (sum),
    .narrow_i  (xl_narrow_i),
    .mask_en_i (mask_en_q),
    .mask_i    (eff_mask),
    .base_en_i (base_en_q),
    .base_i    (eff_base),
    .addr_o    (shaped)
  );

  pm_agu_eff #(.DW(DW), .NARROW_W(NARROW_W)) i_eff (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_wr_i    (csr_wr_i),
    .xl_change_i (xl_change_i),
    .narrow_i    (xl_narrow_i),
    .raw_mask_i  (raw_mask_i),
    .raw_base_i  (raw_base_i),
    .mask_en_i   (mask_en_i),
    .base_en_i   (base_en_i),
    .eff_mask_o  (eff_mask),
    .eff_base_o  (eff_base),
    .mask_en_o   (mask_en_q),
    .base_en_o   (base_en_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) addr_q <= shaped;
    end
  end

  assign busy_o       = csr_wr_i | xl_change_i;
  assign addr_valid_o = valid_q;
  assign addr_o       = addr_q;
endmodule

// File: rtl/pm_agu_chk.sv
module pm_agu_chk #(
  parameter int DW       = 64,
  parameter int NARROW_W = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          xl_narrow_i,
  input logic          xl_change_i,
  input logic          csr_wr_i,
  input logic [DW-1:0] raw_mask_i,
  input logic          addr_valid_o,
  input logic [DW-1:0] addr_o,
  input logic [DW-1:0] eff_mask,
  input logic [DW-1:0] eff_base,
  input logic          mask_en_q,
  input logic          base_en_q
);
  assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> addr_valid_o);

  assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!addr_valid_o && $stable(addr_o)));

  assert_narrow_ext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && xl_narrow_i && !base_en_q) |=> ((addr_o >> NARROW_W) == '0));

  assert_mask_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mask_en_q && !base_en_q) |=> ((addr_o & $past(eff_mask)) == '0));

  assert_base_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && base_en_q) |=> ((addr_o & $past(eff_base)) == $past(eff_base)));

  assert_trunc_narrow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((csr_wr_i || xl_change_i) && xl_narrow_i) |=>
      (((eff_mask >> NARROW_W) == '0) && ((eff_base >> NARROW_W) == '0)));

  assert_wide_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && !xl_narrow_i) |=> (eff_mask == $past(raw_mask_i)));

  assert_eff_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_wr_i || xl_change_i) |=> ($stable(eff_mask) && $stable(eff_base)));
endmodule

bind pm_agu pm_agu_chk #(.DW(DW), .NARROW_W(NARROW_W)) i_pm_agu_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .xl_narrow_i  (xl_narrow_i),
  .xl_change_i  (xl_change_i),
  .csr_wr_i     (csr_wr_i),
  .raw_mask_i   (raw_mask_i),
  .addr_valid_o (addr_valid_o),
  .addr_o       (addr_o),
  .eff_mask     (eff_mask),
  .eff_base     (eff_base),
  .mask_en_q    (mask_en_q),
  .base_en_q    (base_en_q)
);

// File: tb/test_pm_agu.sv
`timescale 1ns/1ps
module test_pm_agu;
  localparam int DW = 16;
  localparam int NW = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, amode = 1'b0;
  logic [DW-1:0] rs1 = '0, idx = '0;
  logic [IW-1:0] imm = '0;
  logic          xl_narrow = 1'b0, xl_change = 1'b0, csr_wr = 1'b0;
  logic [DW-1:0] raw_mask = '0, raw_base = '0;
  logic          mask_en = 1'b0, base_en = 1'b0;
  logic          busy, addr_valid;
  logic [DW-1:0] addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of captured state
  logic [DW-1:0] m_raw_mask = '0, m_raw_base = '0, m_eff_mask = '0, m_eff_base = '0;
  logic          m_men = 1'b0, m_ben = 1'b0;
  logic [DW-1:0] last_addr = '0;

  always #2.5 clk = ~clk;

  pm_agu #(.DW(DW), .NARROW_W(NW), .IMM_W(IW)) i_pm_agu (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .amode_i(amode),
    .rs1_i(rs1), .imm_i(imm), .idx_i(idx), .xl_narrow_i(xl_narrow),
    .xl_change_i(xl_change), .csr_wr_i(csr_wr), .raw_mask_i(raw_mask),
    .raw_base_i(raw_base), .mask_en_i(mask_en), .base_en_i(base_en),
    .busy_o(busy), .addr_valid_o(addr_valid), .addr_o(addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_addr(input logic md, input logic [DW-1:0] a,
      input logic [IW-1:0] im, input logic [DW-1:0] ix, input logic nar);
    logic [DW-1:0] s;
    s = md ? DW'(a + ix) : DW'(a + {{(DW-IW){im[IW-1]}}, im});
    if (nar) s = s & DW'((1 << NW) - 1);
    if (m_men) s = s & ~m_eff_mask;
    if (m_ben) s = s | m_eff_base;
    return s;
  endfunction

  function automatic logic [DW-1:0] fitv(input logic [DW-1:0] v, input logic nar);
    return nar ? (v & DW'((1 << NW) - 1)) : v;
  endfunction

  // one cycle: drive at negedge, check busy, check outputs at next negedge
  task automatic cyc(input string req, input logic rq, input logic md, input logic [DW-1:0] a,
      input logic [IW-1:0] im, input logic [DW-1:0] ix, input logic nar,
      input logic wr, input logic [DW-1:0] mk, input logic [DW-1:0] bs,
      input logic me, input logic be, input logic chg);
    logic [DW-1:0] e;
    req_valid = rq; amode = md; rs1 = a; imm = im; idx = ix; xl_narrow = nar;
    csr_wr = wr; raw_mask = mk; raw_base = bs; mask_en = me; base_en = be; xl_change = chg;
    #1;
    check("R8 busy", 32'(busy), 32'(wr | chg));
    e = rq ? exp_addr(md, a, im, ix, nar) : last_addr;
    if (wr) begin
      m_raw_mask = mk; m_raw_base = bs; m_men = me; m_ben = be;
    end
    if (wr || chg) begin
      m_eff_mask = fitv(m_raw_mask, nar);
      m_eff_base = fitv(m_raw_base, nar);
    end
    @(posedge clk);
    @(negedge clk);
    check({req, " valid"}, 32'(addr_valid), 32'(rq));
    check(req, 32'(addr), 32'(e));
    last_addr = e;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 valid after reset", 32'(addr_valid), 0);
    check("R10 addr after reset", 32'(addr), 0);
    check("R10 busy after reset", 32'(busy), 0);
    // enables off after reset: plain (extended) sum
    cyc("R10 R3 narrow sum, no masking", 1, 0, 16'h12F0, 4'h3, '0, 1, 0, '0, '0, 0, 0, 0);
    cyc("R10 wide sum, no masking", 1, 1, 16'hFFF0, '0, 16'h0025, 0, 0, '0, '0, 0, 0, 0);

    // sweep: width x enables x rs1 x imm x mode
    for (int xl = 0; xl < 2; xl++) begin
      for (int cf = 0; cf < 4; cf++) begin
        cyc("R6 write", 0, 0, '0, '0, '0, xl[0], 1, 16'hF0F1, 16'h3A11,
            cf[0], cf[1], 0);
        for (int r = 0; r < 16; r++) begin
          for (int im = 0; im < 16; im++) begin
            for (int md = 0; md < 2; md++) begin
              logic [DW-1:0] a, ix;
              a  = DW'(r * 4099 + 16'h00F7);
              ix = DW'(im * 257 + r * 31 + 16'hFF80);
              cyc(md[0] ? "R2 R3 R4 R5 index" : "R1 R3 R4 R5 imm",
                  1, md[0], a, IW'(im), ix, xl[0], 0, '0, '0, 0, 0, 0);
            end
          end
        end
      end
    end

    // R9: idle cycle keeps address
    cyc("R9 idle hold", 0, 0, 16'h5555, 4'h1, '0, 0, 0, '0, '0, 0, 0, 0);

    // R7 R8 sequence: wide write, then width moves without a rebuild
    cyc("R6 wide write", 0, 0, '0, '0, '0, 0, 1, 16'hFFF0, 16'h1234, 1, 1, 0);
    cyc("R7 no rebuild on width move", 1, 1, 16'h0100, '0, 16'h0057, 1, 0, '0, '0, 0, 0, 0);
    cyc("R8 old values during rebuild", 1, 1, 16'h0100, '0, 16'h0057, 1, 0, '0, '0, 0, 0, 1);
    cyc("R7 rebuilt narrow values", 1, 1, 16'h0100, '0, 16'h0057, 1, 0, '0, '0, 0, 0, 0);
    cyc("R7 rebuild back to wide", 0, 0, '0, '0, '0, 0, 0, '0, '0, 0, 0, 1);
    cyc("R7 wide values restored", 1, 0, 16'h8000, 4'hF, '0, 0, 0, '0, '0, 0, 0, 0);
    // write and request in the same cycle
    cyc("R8 old values during write", 1, 0, 16'h00FF, 4'h1, '0, 0, 1, 16'h000F, 16'h8000, 1, 0, 0);
    cyc("R8 new values after write", 1, 0, 16'h00FF, 4'h1, '0, 0, 0, '0, '0, 0, 0, 0);
    cyc("R9 idle hold after write", 0, 0, '0, '0, '0, 0, 0, '0, '0, 0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule